// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block watches the stream of bus writes that reach a flash device and turns it into commands. A write is one clock cycle with `wr_valid` high, which carries an address, a byte-select bit and a data word. Most commands open with two fixed unlock writes. The addresses of those unlock writes depend on whether the bus is in byte mode or word mode. The third write carries an opcode. Some commands then take one or more further writes. When a command completes, the decoder raises a one-cycle pulse for it. For program and sector erase, it also latches the target address and data for the program/erase engine that sits beside it.

The decoder keeps two modes of its own. Identify mode lets a small read mux return a maker code, a device code or a per-sector protect flag. Bypass mode shortens each program operation to two writes. The engine reports what it is doing on `eng_state`. While it is programming or doing a whole-chip erase, the decoder ignores every write. While it is erasing sectors, the decoder accepts only suspend and reset. While the engine's acceptance window is open, it also accepts add-sector writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, every command pulse is low and both `id_mode` and `bypass_mode` are 0. The sequence tracker starts at its idle read state.
- R2: An unlock write is data AA then data 55. In word mode these go to 555 then 2AA, where the key is address bits [10:0]. In byte mode they go to AAA then 555, where the key is {address bits [10:0], `wr_lsb`}. The decoder compares only those key bits and data bits [7:0].
- R3: The sequence unlock, unlock, A0 to the first unlock address, then any write raises `cmd_program`. It latches `tgt_addr` = {`wr_addr`, `wr_lsb`} and `tgt_data` = `wr_data` from that last write.
- R4: Opcode 90 in the third write sets `id_mode`. While `id_mode` is 1, `id_data` follows `rd_sel`: 00 gives MAKER_CODE, 01 gives DEVICE_CODE, 10 gives {7'b0, `prot_flag`} and 11 gives 00. While `id_mode` is 0, `id_data` is 00.
- R5: A reset command raises `cmd_reset` and clears `id_mode`. It can be a single F0 write at any address in the idle read state, or opcode F0 in the third write.
- R6: Opcode 20 in the third write sets `bypass_mode`. In bypass mode, A0 followed by any write raises `cmd_program` with the latched address and data. 90 followed by 00 clears bypass mode. 90 followed by any other value leaves bypass mode set. F0 raises `cmd_reset`. All other writes have no effect.
- R7: Opcode 80 in the third write, then the two unlock writes again, then a final write completes an erase. A final 10 to the first unlock address raises `cmd_chip_erase`. A final 30 at any address raises `cmd_sector_erase` and latches that address in `tgt_addr`.
- R8: A write that does not fit the sequence in progress returns the tracker to the idle read state and clears `id_mode`, with no pulse. After that, a complete sequence is decoded normally.
- R9: While `eng_state` is 1 (program) or 2 (chip erase), every write is ignored. No pulse is raised and the sequence position does not change.
- R10: While `eng_state` is 3 (sector erase), B0 raises `cmd_suspend` and F0 raises `cmd_reset`. A 30 write raises `cmd_add_sector` with its address in `tgt_addr`, but only if `erase_window` is 1 in that cycle. Every other write is ignored.
- R11: While `eng_state` is 0, a single 30 write in the idle read state raises `cmd_resume`. A single B0 write raises nothing.
- R12: Every pulse is high for exactly the one cycle after the write that completes its command. At most one pulse is high in any cycle, and no pulse follows a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 selects byte-wide unlock addresses |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_lsb | input | 1 | Byte-select address bit used in byte mode |
| wr_data | input | DATA_W | Write data |
| eng_state | input | 2 | Engine activity: 0 idle, 1 program, 2 chip erase, 3 sector erase |
| erase_window | input | 1 | Sector-erase add window is open |
| rd_sel | input | 2 | Low read-address bits for identify reads |
| prot_flag | input | 1 | Protect flag of the addressed sector |
| cmd_reset | output | 1 | Reset command pulse |
| cmd_program | output | 1 | Program command pulse |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_sector_erase | output | 1 | Sector erase start pulse |
| cmd_add_sector | output | 1 | Additional sector pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| tgt_addr | output | ADDR_W+1 | Latched {address, byte-select} |
| tgt_data | output | DATA_W | Latched program data |
| id_mode | output | 1 | Identify mode active |
| bypass_mode | output | 1 | Bypass mode active |
| id_data | output | 8 | Identify read data |

## Verification
The same 30 opcode has three meanings, chosen by the engine state and the window flag in the cycle of the write. It can be a resume, a sector erase, or an add-sector, and it must not be dropped or taken as the wrong one. The bench issues 30 writes while the sector-erase window is open, then again in the cycle the window closes, then again once the engine is idle. It expects an add-sector pulse carrying the address, then silence, then a resume pulse. It also checks that an engine going busy in the middle of an unlock sequence freezes that sequence, so that a later opcode write does not complete a command.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_PROG = 2'd1,
        ENG_CHIP = 2'd2,
        ENG_SECT = 2'd3
    } eng_t;

    typedef enum logic [3:0] {
        S_READ, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5, S_BYP, S_BPGM, S_BRST
    } seq_t;

    typedef struct packed {
        logic rst;
        logic pgm;
        logic chip;
        logic sect;
        logic add;
        logic susp;
        logic resm;
    } pulse_t;

    localparam int CMP_BITS = 11;
    localparam int KEY_W    = CMP_BITS + 1;

    localparam logic [7:0] OP_UNLK_A = 8'hAA;
    localparam logic [7:0] OP_UNLK_B = 8'h55;
    localparam logic [7:0] OP_RESET  = 8'hF0;
    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_PROG   = 8'hA0;
    localparam logic [7:0] OP_BYPASS = 8'h20;
    localparam logic [7:0] OP_ERASE  = 8'h80;
    localparam logic [7:0] OP_CHIP   = 8'h10;
    localparam logic [7:0] OP_SECT   = 8'h30;
    localparam logic [7:0] OP_SUSP   = 8'hB0;
    localparam logic [7:0] OP_BYPEXIT = 8'h00;

    // Unlock key expected for the first (second=0) or second (second=1) write
    function automatic logic [KEY_W-1:0] unlock_key(input logic second, input logic byte_mode);
        if (byte_mode) return second ? 12'h555 : 12'hAAA;
        else           return second ? 12'h2AA : 12'h555;
    endfunction

endpackage

// File: rtl/fcd_match.sv
module fcd_match
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    output logic              at_u1,
    output logic              at_u2,
    output logic [7:0]        code
);
    logic [KEY_W-1:0] key;

    always_comb begin
        key   = byte_mode ? {wr_addr[CMP_BITS-1:0], wr_lsb} : {1'b0, wr_addr[CMP_BITS-1:0]};
        at_u1 = (key == unlock_key(1'b0, byte_mode));
        at_u2 = (key == unlock_key(1'b1, byte_mode));
        code  = wr_data[7:0];
    end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic              at_u1,
    input  logic              at_u2,
    input  logic [7:0]        code,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [DATA_W-1:0] wr_data,
    input  eng_t              eng,
    input  logic              erase_window,
    output pulse_t            pulses,
    output logic [ADDR_W:0]   tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              id_mode,
    output logic              bypass_mode
);
    seq_t   st, st_n;
    pulse_t ev;
    logic   cap, id_n, byp_n;

    always_comb begin
        st_n  = st;
        ev    = '0;
        cap   = 1'b0;
        id_n  = id_mode;
        byp_n = bypass_mode;
        if (wr_valid) begin
            unique case (eng)
                ENG_SECT: begin
                    if (code == OP_RESET) begin
                        ev.rst = 1'b1;
                        id_n   = 1'b0;
                    end else if (code == OP_SUSP) begin
                        ev.susp = 1'b1;
                    end else if (code == OP_SECT && erase_window) begin
                        ev.add = 1'b1;
                        cap    = 1'b1;
                    end
                end
                ENG_IDLE: begin
                    unique case (st)
                        S_READ: begin
                            if (code == OP_RESET) begin
                                ev.rst = 1'b1;
                                id_n   = 1'b0;
                            end else if (code == OP_SECT) begin
                                ev.resm = 1'b1;
                            end else if (code == OP_UNLK_A && at_u1) begin
                                st_n = S_U1;
                            end
                        end
                        S_U1: begin
                            if (code == OP_UNLK_B && at_u2) st_n = S_U2;
                            else begin st_n = S_READ; id_n = 1'b0; end
                        end
                        S_U2: begin
                            st_n = S_READ;
                            if (!at_u1) id_n = 1'b0;
                            else begin
                                unique case (code)
                                    OP_RESET:  begin ev.rst = 1'b1; id_n = 1'b0; end
                                    OP_IDENT:  id_n = 1'b1;
                                    OP_PROG:   st_n = S_PGM;
                                    OP_BYPASS: begin byp_n = 1'b1; id_n = 1'b0; st_n = S_BYP; end
                                    OP_ERASE:  st_n = S_E3;
                                    default:   id_n = 1'b0;
                                endcase
                            end
                        end
                        S_PGM: begin
                            ev.pgm = 1'b1;
                            cap    = 1'b1;
                            id_n   = 1'b0;
                            st_n   = S_READ;
                        end
                        S_E3: begin
                            if (code == OP_UNLK_A && at_u1) st_n = S_E4;
                            else begin st_n = S_READ; id_n = 1'b0; end
                        end
                        S_E4: begin
                            if (code == OP_UNLK_B && at_u2) st_n = S_E5;
                            else begin st_n = S_READ; id_n = 1'b0; end
                        end
                        S_E5: begin
                            st_n = S_READ;
                            id_n = 1'b0;
                            if (code == OP_CHIP && at_u1) ev.chip = 1'b1;
                            else if (code == OP_SECT) begin
                                ev.sect = 1'b1;
                                cap     = 1'b1;
                            end
                        end
                        S_BYP: begin
                            if (code == OP_PROG)       st_n = S_BPGM;
                            else if (code == OP_IDENT) st_n = S_BRST;
                            else if (code == OP_RESET) ev.rst = 1'b1;
                        end
                        S_BPGM: begin
                            ev.pgm = 1'b1;
                            cap    = 1'b1;
                            st_n   = S_BYP;
                        end
                        S_BRST: begin
                            if (code == OP_BYPEXIT) begin
                                byp_n = 1'b0;
                                st_n  = S_READ;
                            end else st_n = S_BYP;
                        end
                        default: st_n = S_READ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_READ;
            pulses      <= '0;
            id_mode     <= 1'b0;
            bypass_mode <= 1'b0;
            tgt_addr    <= '0;
            tgt_data    <= '0;
        end else begin
            st          <= st_n;
            pulses      <= ev;
            id_mode     <= id_n;
            bypass_mode <= byp_n;
            if (cap) begin
                tgt_addr <= {wr_addr, wr_lsb};
                tgt_data <= wr_data;
            end
        end
    end

    // R12
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulses));

    // R12
    no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (pulses == '0));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && (eng == ENG_PROG || eng == ENG_CHIP)) |=> ((pulses == '0) && $stable(st)));

    // R10
    add_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        pulses.add |-> $past(erase_window && wr_valid && eng == ENG_SECT));

    // R6
    bypass_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_mode) |-> $past(wr_valid && at_u1 && code == OP_BYPASS));
endmodule

// File: rtl/fcd_id_rd.sv
module fcd_id_rd #(
    parameter logic [7:0] MAKER_CODE  = 8'h3C,
    parameter logic [7:0] DEVICE_CODE = 8'hC3
) (
    input  logic       id_mode,
    input  logic [1:0] rd_sel,
    input  logic       prot_flag,
    output logic [7:0] id_data
);
    always_comb begin
        id_data = 8'h00;
        if (id_mode) begin
            unique case (rd_sel)
                2'b00:   id_data = MAKER_CODE;
                2'b01:   id_data = DEVICE_CODE;
                2'b10:   id_data = {7'b0, prot_flag};
                default: id_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W      = 16,
    parameter int         DATA_W      = 16,
    parameter logic [7:0] MAKER_CODE  = 8'h3C,
    parameter logic [7:0] DEVICE_CODE = 8'hC3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_mode,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        eng_state,
    input  logic              erase_window,
    input  logic [1:0]        rd_sel,
    input  logic              prot_flag,
    output logic              cmd_reset,
    output logic              cmd_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sector_erase,
    output logic              cmd_add_sector,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic [ADDR_W:0]   tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              id_mode,
    output logic              bypass_mode,
    output logic [7:0]        id_data
);
    logic       at_u1, at_u2;
    logic [7:0] code;
    pulse_t     pulses;

    fcd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
        .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_data(wr_data), .byte_mode(byte_mode),
        .at_u1(at_u1), .at_u2(at_u2), .code(code)
    );

    fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .at_u1(at_u1), .at_u2(at_u2),
        .code(code), .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_data(wr_data),
        .eng(eng_t'(eng_state)), .erase_window(erase_window), .pulses(pulses),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .id_mode(id_mode),
        .bypass_mode(bypass_mode)
    );

    fcd_id_rd #(.MAKER_CODE(MAKER_CODE), .DEVICE_CODE(DEVICE_CODE)) id_i (
        .id_mode(id_mode), .rd_sel(rd_sel), .prot_flag(prot_flag), .id_data(id_data)
    );

    assign cmd_reset        = pulses.rst;
    assign cmd_program      = pulses.pgm;
    assign cmd_chip_erase   = pulses.chip;
    assign cmd_sector_erase = pulses.sect;
    assign cmd_add_sector   = pulses.add;
    assign cmd_suspend      = pulses.susp;
    assign cmd_resume       = pulses.resm;
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
    localparam logic [6:0] P_NONE = 7'b0000000;
    localparam logic [6:0] P_RST  = 7'b1000000;
    localparam logic [6:0] P_PGM  = 7'b0100000;
    localparam logic [6:0] P_CHIP = 7'b0010000;
    localparam logic [6:0] P_SECT = 7'b0001000;
    localparam logic [6:0] P_ADD  = 7'b0000100;
    localparam logic [6:0] P_SUSP = 7'b0000010;
    localparam logic [6:0] P_RESM = 7'b0000001;

    logic        clk = 0, rst = 1, byte_mode = 0, wr_valid = 0, wr_lsb = 0;
    logic [15:0] wr_addr = 0, wr_data = 0;
    logic [1:0]  eng_state = 0, rd_sel = 0;
    logic        erase_window = 0, prot_flag = 0;
    logic        cmd_reset, cmd_program, cmd_chip_erase, cmd_sector_erase;
    logic        cmd_add_sector, cmd_suspend, cmd_resume, id_mode, bypass_mode;
    logic [16:0] tgt_addr;
    logic [15:0] tgt_data;
    logic [7:0]  id_data;
    logic [6:0]  p;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_data(wr_data), .eng_state(eng_state),
        .erase_window(erase_window), .rd_sel(rd_sel), .prot_flag(prot_flag),
        .cmd_reset(cmd_reset), .cmd_program(cmd_program), .cmd_chip_erase(cmd_chip_erase),
        .cmd_sector_erase(cmd_sector_erase), .cmd_add_sector(cmd_add_sector),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .tgt_addr(tgt_addr),
        .tgt_data(tgt_data), .id_mode(id_mode), .bypass_mode(bypass_mode), .id_data(id_data)
    );

    function automatic logic [6:0] pvec();
        return {cmd_reset, cmd_program, cmd_chip_erase, cmd_sector_erase,
                cmd_add_sector, cmd_suspend, cmd_resume};
    endfunction

    function automatic logic [7:0] exp_id(input logic [1:0] s, input logic pf, input logic idm);
        if (!idm) return 8'h00;
        case (s)
            2'b00:   return 8'h3C;
            2'b01:   return 8'hC3;
            2'b10:   return {7'b0, pf};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one write; p holds the pulse vector seen the cycle after
    task automatic wr(input logic [15:0] a, input logic l, input logic [15:0] d);
        wr_addr = a; wr_lsb = l; wr_data = d; wr_valid = 1;
        @(posedge clk);
        @(negedge clk);
        p = pvec();
        wr_valid = 0;
    endtask

    task automatic u1(input logic [15:0] d);
        wr(16'h0555, 1'b0, d);
    endtask
    task automatic u2(input logic [15:0] d);
        if (byte_mode) wr(16'h02AA, 1'b1, d);
        else           wr(16'h02AA, 1'b0, d);
    endtask
    task automatic unlock();
        u1(16'h00AA); u2(16'h0055);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pulses", pvec(), P_NONE);
        chk("R1 id_mode", id_mode, 0);
        chk("R1 bypass_mode", bypass_mode, 0);

        // R3 word-mode program
        unlock(); chk("R3 no early pulse", p, P_NONE);
        u1(16'h00A0); chk("R3 no pulse on opcode", p, P_NONE);
        wr(16'h1234, 1'b0, 16'hBEEF);
        chk("R3 program pulse", p, P_PGM);
        chk("R3 tgt_addr", tgt_addr, {16'h1234, 1'b0});
        chk("R3 tgt_data", tgt_data, 16'hBEEF);
        @(negedge clk);
        chk("R12 pulse one cycle", pvec(), P_NONE);

        // R4 identify
        unlock(); u1(16'h0090);
        chk("R4 id_mode set", id_mode, 1);
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 2; f++) begin
                rd_sel = s[1:0]; prot_flag = f[0]; #1;
                chk("R4 id_data", id_data, exp_id(s[1:0], f[0], 1'b1));
            end
        end
        // R5 single F0 at arbitrary address
        wr(16'h7E31, 1'b0, 16'h00F0);
        chk("R5 reset pulse", p, P_RST);
        chk("R5 id cleared", id_mode, 0);
        rd_sel = 2'b00; #1;
        chk("R4 id_data off", id_data, 8'h00);
        // R5 three-write reset
        unlock(); u1(16'h00F0);
        chk("R5 three-write reset", p, P_RST);

        // R2 byte mode
        byte_mode = 1;
        unlock(); u1(16'h00A0); wr(16'h0F0F, 1'b1, 16'h00C5);
        chk("R2 byte program", p, P_PGM);
        chk("R2 byte tgt_addr", tgt_addr, {16'h0F0F, 1'b1});
        wr(16'h0555, 1'b1, 16'h00AA); u2(16'h0055); u1(16'h00A0); wr(16'h0001, 1'b0, 16'h0011);
        chk("R2 byte wrong lsb", p, P_NONE);
        byte_mode = 0;
        // R2 upper address/data bits ignored
        wr(16'hF555, 1'b0, 16'h77AA); wr(16'h32AA, 1'b0, 16'h9955); wr(16'h8555, 1'b0, 16'h12A0);
        wr(16'h4444, 1'b0, 16'h5678);
        chk("R2 upper bits ignored", p, P_PGM);
        // R2 word mode rejects byte-mode addresses
        wr(16'h0555, 1'b0, 16'h00AA); wr(16'h0555, 1'b0, 16'h0055); u1(16'h00A0);
        wr(16'h0002, 1'b0, 16'h0022);
        chk("R2 word wrong addr", p, P_NONE);

        // R6 bypass
        unlock(); u1(16'h0020);
        chk("R6 bypass set", bypass_mode, 1);
        for (int i = 0; i < 20; i++) begin
            logic [15:0] a, d;
            a = 16'($urandom); d = 16'($urandom);
            wr(16'h0000, 1'b0, 16'h00A0);
            wr(a, 1'b0, d);
            chk("R6 bypass program", p, P_PGM);
            chk("R6 bypass addr", tgt_addr, {a, 1'b0});
            chk("R6 bypass data", tgt_data, d);
        end
        unlock(); u1(16'h0090);
        chk("R6 ignored in bypass", p, P_NONE);
        chk("R6 ignored keeps id off", id_mode, 0);
        wr(16'h0000, 1'b0, 16'h0090); wr(16'h0000, 1'b0, 16'h0001);
        chk("R6 90/01 stays", bypass_mode, 1);
        wr(16'h0000, 1'b0, 16'h00F0);
        chk("R6 reset in bypass", p, P_RST);
        chk("R6 reset keeps bypass", bypass_mode, 1);
        wr(16'h0000, 1'b0, 16'h0090); wr(16'h0000, 1'b0, 16'h0000);
        chk("R6 exit bypass", bypass_mode, 0);

        // R7 erase
        unlock(); u1(16'h0080); unlock(); u1(16'h0010);
        chk("R7 chip erase", p, P_CHIP);
        unlock(); u1(16'h0080); unlock(); wr(16'h3C00, 1'b0, 16'h0030);
        chk("R7 sector erase", p, P_SECT);
        chk("R7 sector addr", tgt_addr, {16'h3C00, 1'b0});

        // R8 broken sequence
        unlock(); u1(16'h0090);
        unlock(); u1(16'h0077);
        chk("R8 broken no pulse", p, P_NONE);
        chk("R8 broken clears id", id_mode, 0);
        unlock(); u1(16'h00A0); wr(16'h0042, 1'b0, 16'h0042);
        chk("R8 fresh sequence", p, P_PGM);

        // R9 busy program: writes ignored, sequence frozen
        eng_state = 2'd1;
        wr(16'h0000, 1'b0, 16'h00F0);
        chk("R9 prog busy F0", p, P_NONE);
        unlock();
        eng_state = 2'd0;
        u1(16'h00A0); wr(16'h0009, 1'b0, 16'h0009);
        chk("R9 frozen sequence", p, P_NONE);
        eng_state = 2'd2;
        wr(16'h0000, 1'b0, 16'h00B0);
        chk("R9 chip busy B0", p, P_NONE);
        wr(16'h0000, 1'b0, 16'h00F0);
        chk("R9 chip busy F0", p, P_NONE);

        // R10 sector erase busy
        eng_state = 2'd3; erase_window = 1;
        wr(16'h2000, 1'b1, 16'h0030);
        chk("R10 add sector", p, P_ADD);
        chk("R10 add addr", tgt_addr, {16'h2000, 1'b1});
        wr(16'h0555, 1'b0, 16'h00AA);
        chk("R10 other ignored", p, P_NONE);
        erase_window = 0;
        wr(16'h6000, 1'b0, 16'h0030);
        chk("R10 window closed", p, P_NONE);
        chk("R10 addr kept", tgt_addr, {16'h2000, 1'b1});
        wr(16'h0000, 1'b0, 16'h00B0);
        chk("R10 suspend", p, P_SUSP);
        wr(16'h0000, 1'b0, 16'h00F0);
        chk("R10 reset", p, P_RST);

        // R11 idle single writes
        eng_state = 2'd0;
        wr(16'h1111, 1'b0, 16'h0030);
        chk("R11 resume", p, P_RESM);
        wr(16'h1111, 1'b0, 16'h00B0);
        chk("R11 B0 ignored", p, P_NONE);

        // R12 random non-command writes in read state
        for (int i = 0; i < 200; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            if (d[7:0] == 8'hF0 || d[7:0] == 8'h30 || d[7:0] == 8'hAA) d[7:0] = 8'h01;
            wr(16'($urandom), 1'($urandom), d);
            chk("R12 random no pulse", p, P_NONE);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule